// File: doc/BRIEF.md
# Pointer-Indexed Serial Status Port

This block is a small console serial endpoint reached through two byte-wide addresses. One address carries commands on writes and status on reads; the other moves data bytes. A command write always loads an internal view pointer, and the pointer chooses what the next status read returns. One pointer value selects a compact "which interrupt" view, and reading that view returns the pointer to its default. One command byte doubles as the transmit-interrupt acknowledge.

Received bytes come from a ready/valid source and are popped by data-port reads. Transmit bytes written to the data port are held in a one-byte register toward a ready/valid sink. Two pending flags, one for receive and one for transmit, feed a single interrupt line. No enable gates either flag. Illegal accesses change nothing except a sticky error output.

Top module: `scs_port`

## Requirements
- R1: After reset, irq, err and tx_valid are low, and the pointer is 0, so a status read returns 0x04.
- R2: Every command-port (offset 0x80) write loads the written byte into the pointer. The one exception is a rejected acknowledge.
- R3: When the pointer is not 3, a status read returns 0x04, with bit 0 also set while receive is pending. All other bits are 0.
- R4: When the pointer is 3, a status read returns 0x10 if transmit is pending, else 0x20 if receive is pending, else 0x00, and the pointer becomes 0 on that read.
- R5: A command write of 0x28 while transmit is pending clears the transmit flag on the next cycle. If transmit is not pending, the same write sets err and changes neither the flags nor the pointer.
- R6: A data-port (offset 0xC0) write while tx_valid is low sets tx_valid and the transmit flag on the next cycle, with tx_data equal to the byte. tx_valid and tx_data then hold until a cycle with tx_ready high.
- R7: A data-port write while tx_valid is high sets err and leaves tx_data, tx_valid and the flags unchanged.
- R8: A data-port read while rx_valid is high returns rx_data in the same cycle, raises rx_ready in that cycle, and clears the receive flag on the next cycle.
- R9: A data-port read while rx_valid is low returns 0x00, sets err and leaves rx_ready low.
- R10: In any cycle where rx_valid is high and no data read pops the byte, the receive flag is set on the next cycle. No enable is involved.
- R11: irq is high exactly while either pending flag is set.
- R12: err stays high from its first setting until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access offset |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, valid in the access cycle |
| rx_valid | input | 1 | Receive source has a byte |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Byte popped this cycle |
| tx_valid | output | 1 | Transmit byte held for the sink |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Sink takes the byte |
| irq | output | 1 | Interrupt, high while any flag is pending |
| err | output | 1 | Sticky error |

## Verification
A transmit acknowledge and the arrival of a fresh receive byte can land in the same cycle. That cycle must clear one flag and set the other, so irq must stay high without a dip. The bench provokes this with a directed step that writes 0x28 while rx_valid rises. It also arises in the random phase, where rx_valid toggles freely under command traffic. A reference model in the bench updates both flags from the same pre-edge inputs and judges irq, the status view and the error flag each cycle.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [7:0]  ACK_CMD   = 8'h28;
  localparam logic [7:0]  VIEW_PTR  = 8'h03;
  localparam int unsigned DEF_BIT   = 2;
  localparam int unsigned RXP_BIT   = 0;
  localparam int unsigned TXV_BIT   = 4;
  localparam int unsigned RXV_BIT   = 5;

  typedef struct packed {
    logic cmd_load;
    logic ack_ok;
    logic ack_bad;
    logic stat_rd;
    logic dwr_ok;
    logic dwr_bad;
    logic drd_ok;
    logic drd_bad;
  } scs_act_t;
endpackage

// File: rtl/scs_decode.sv
module scs_decode
  import scs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h80,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'hC0
) (
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BYTE_W-1:0] acc_wdata,
  input  logic              tx_pend,
  input  logic              tx_busy,
  input  logic              rx_valid,
  output scs_act_t          act
);
  logic hit_stat, hit_data, is_ack;

  always_comb begin
    hit_stat     = acc_en && (acc_addr == STAT_OFS);
    hit_data     = acc_en && (acc_addr == DATA_OFS);
    is_ack       = (acc_wdata == ACK_CMD);
    act.ack_ok   = hit_stat && acc_wr && is_ack && tx_pend;
    act.ack_bad  = hit_stat && acc_wr && is_ack && !tx_pend;
    act.cmd_load = hit_stat && acc_wr && !act.ack_bad;
    act.stat_rd  = hit_stat && !acc_wr;
    act.dwr_ok   = hit_data && acc_wr && !tx_busy;
    act.dwr_bad  = hit_data && acc_wr && tx_busy;
    act.drd_ok   = hit_data && !acc_wr && rx_valid;
    act.drd_bad  = hit_data && !acc_wr && !rx_valid;
  end
endmodule

// File: rtl/scs_state.sv
module scs_state
  import scs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_i,
  input  scs_act_t          act,
  input  logic [BYTE_W-1:0] acc_wdata,
  input  logic              rx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] ptr_q,
  output logic              tx_pend_q,
  output logic              rx_pend_q,
  output logic              err_q,
  output logic              txv_q,
  output logic [BYTE_W-1:0] txd_q
);
  logic [BYTE_W-1:0] ptr_d;
  logic tx_pend_d, rx_pend_d, err_d, txv_d, txd_en;

  always_comb begin
    ptr_d = ptr_q;
    if (act.cmd_load)
      ptr_d = acc_wdata;
    else if (act.stat_rd && (ptr_q == VIEW_PTR))
      ptr_d = '0;

    tx_pend_d = tx_pend_q;
    if (act.ack_ok)
      tx_pend_d = 1'b0;
    else if (act.dwr_ok)
      tx_pend_d = 1'b1;

    rx_pend_d = rx_pend_q;
    if (act.drd_ok)
      rx_pend_d = 1'b0;
    else if (rx_valid)
      rx_pend_d = 1'b1;

    err_d = err_q | act.ack_bad | act.dwr_bad | act.drd_bad;

    txd_en = act.dwr_ok;
    txv_d  = txv_q;
    if (act.dwr_ok)
      txv_d = 1'b1;
    else if (txv_q && tx_ready)
      txv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ptr_q     <= '0;
      tx_pend_q <= 1'b0;
      rx_pend_q <= 1'b0;
      err_q     <= 1'b0;
      txv_q     <= 1'b0;
      txd_q     <= '0;
    end else begin
      ptr_q     <= ptr_d;
      tx_pend_q <= tx_pend_d;
      rx_pend_q <= rx_pend_d;
      err_q     <= err_d;
      txv_q     <= txv_d;
      if (txd_en)
        txd_q <= acc_wdata;
    end
  end
endmodule

// File: rtl/scs_status_enc.sv
module scs_status_enc
  import scs_pkg::*;
(
  input  logic [BYTE_W-1:0] ptr,
  input  logic              tx_pend,
  input  logic              rx_pend,
  output logic [BYTE_W-1:0] stat
);
  always_comb begin
    stat = '0;
    if (ptr == VIEW_PTR) begin
      if (tx_pend)
        stat[TXV_BIT] = 1'b1;
      else if (rx_pend)
        stat[RXV_BIT] = 1'b1;
    end else begin
      stat[DEF_BIT] = 1'b1;
      stat[RXP_BIT] = rx_pend;
    end
  end
endmodule

// File: rtl/scs_port.sv
module scs_port
  import scs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h80,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'hC0,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq,
  output logic              err
);
  logic [SYNC_LEN-1:0] rst_sync;
  logic                rst_i;
  scs_act_t            act;
  logic [BYTE_W-1:0]   ptr_q, stat;
  logic                tx_pend_q, rx_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= '0;
    else
      rst_sync <= {rst_sync[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_i = rst_sync[SYNC_LEN-1];

  scs_decode #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .DATA_OFS(DATA_OFS)) u_dec (
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .tx_pend(tx_pend_q), .tx_busy(tx_valid), .rx_valid(rx_valid), .act(act)
  );

  scs_state u_st (
    .clk(clk), .rst_i(rst_i), .act(act), .acc_wdata(acc_wdata),
    .rx_valid(rx_valid), .tx_ready(tx_ready), .ptr_q(ptr_q),
    .tx_pend_q(tx_pend_q), .rx_pend_q(rx_pend_q), .err_q(err),
    .txv_q(tx_valid), .txd_q(tx_data)
  );

  scs_status_enc u_enc (
    .ptr(ptr_q), .tx_pend(tx_pend_q), .rx_pend(rx_pend_q), .stat(stat)
  );

  always_comb begin
    acc_rdata = '0;
    if (act.stat_rd)
      acc_rdata = stat;
    else if (act.drd_ok)
      acc_rdata = rx_data;
  end

  assign rx_ready = act.drd_ok;
  assign irq      = tx_pend_q | rx_pend_q;
endmodule

// File: rtl/scs_port_chk.sv
module scs_port_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h80,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'hC0
) (
  input logic              clk,
  input logic              rst_i,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [7:0]        acc_wdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              tx_ready,
  input logic              tx_pend,
  input logic              irq,
  input logic              err
);
  logic wr_data, wr_ack;
  assign wr_data = acc_en && acc_wr && (acc_addr == DATA_OFS);
  assign wr_ack  = acc_en && acc_wr && (acc_addr == STAT_OFS) && (acc_wdata == 8'h28);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_i)
    err |=> err);
  p_pop_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_i)
    rx_ready |-> rx_valid);
  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_tx_load_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_data && !tx_valid) |=> (tx_valid && tx_pend && irq));
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_ack && tx_pend) |=> !tx_pend);
  p_busy_write_err_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_data && tx_valid) |=> err);
  p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(irq) |-> $past(wr_data || rx_valid));
endmodule

bind scs_port scs_port_chk #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .DATA_OFS(DATA_OFS)) u_chk (
  .clk(clk), .rst_i(rst_i), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
  .acc_wdata(acc_wdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
  .tx_pend(tx_pend_q), .irq(irq), .err(err)
);

// File: tb/test_scs_port.sv
module test_scs_port;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] A_ST = 8'h80;
  localparam logic [7:0] A_DT = 8'hC0;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_en, acc_wr, rx_valid, tx_ready;
  logic [7:0] acc_addr, acc_wdata, rx_data;
  logic [7:0] acc_rdata, tx_data;
  logic rx_ready, tx_valid, irq, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_ptr, m_txd;
  logic m_tx, m_rx, m_err, m_txv;

  always #(CLK_PERIOD/2) clk = ~clk;

  scs_port i_scs_port (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .irq(irq), .err(err)
  );

  function automatic logic [7:0] exp_stat();
    if (m_ptr == 8'h03) return m_tx ? 8'h10 : (m_rx ? 8'h20 : 8'h00);
    return 8'h04 | {7'd0, m_rx};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic wr, input logic [7:0] ad, input logic [7:0] wd,
                      input logic rv, input logic [7:0] rd, input logic tr);
    logic [7:0] er;
    logic pop, bad;
    @(negedge clk);
    acc_en = en; acc_wr = wr; acc_addr = ad; acc_wdata = wd;
    rx_valid = rv; rx_data = rd; tx_ready = tr;
    #1;
    er = 8'h00;
    pop = en && !wr && ad == A_DT && rv;
    if (en && !wr && ad == A_ST) er = exp_stat();
    else if (pop) er = rd;
    if (en && !wr && ad == A_ST)
      chk(acc_rdata == er, (m_ptr == 8'h03) ? "R4" : "R3", acc_rdata, er);
    if (en && !wr && ad == A_DT)
      chk(acc_rdata == er, rv ? "R8" : "R9", acc_rdata, er);
    chk(rx_ready == pop, "R8", {7'd0, rx_ready}, {7'd0, pop});
    chk(irq == (m_tx | m_rx), "R11", {7'd0, irq}, {7'd0, m_tx | m_rx});
    chk(err == m_err, "R12", {7'd0, err}, {7'd0, m_err});
    chk(tx_valid == m_txv, "R6", {7'd0, tx_valid}, {7'd0, m_txv});
    if (m_txv) chk(tx_data == m_txd, "R7", tx_data, m_txd);
    @(posedge clk);
    bad = (en && wr && ad == A_ST && wd == 8'h28 && !m_tx) ||
          (en && wr && ad == A_DT && m_txv) || (en && !wr && ad == A_DT && !rv);
    if (en && wr && ad == A_ST && !(wd == 8'h28 && !m_tx)) begin
      m_ptr = wd;
      if (wd == 8'h28) m_tx = 1'b0;
    end else if (en && !wr && ad == A_ST && m_ptr == 8'h03) m_ptr = 8'h00;
    if (en && wr && ad == A_DT && !m_txv) begin
      m_txv = 1'b1; m_txd = wd; m_tx = 1'b1;
    end else if (m_txv && tr) m_txv = 1'b0;
    if (pop) m_rx = 1'b0;
    else if (rv) m_rx = 1'b1;
    if (bad) m_err = 1'b1;
  endtask

  task automatic idle(input logic rv, input logic [7:0] rd, input logic tr);
    step(1'b0, 1'b0, 8'h00, 8'h00, rv, rd, tr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ptr = 0; m_txd = 0; m_tx = 0; m_rx = 0; m_err = 0; m_txv = 0;
    rst_n = 1'b0; acc_en = 0; acc_wr = 0; acc_addr = 0; acc_wdata = 0;
    rx_valid = 0; rx_data = 0; tx_ready = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) idle(1'b0, 8'h00, 1'b0);
    // R1: reset view and outputs
    step(1'b1, 1'b0, A_ST, 8'h00, 1'b0, 8'h00, 1'b0);
    #1 chk(!irq && !err && !tx_valid, "R1", {5'd0, irq, err, tx_valid}, 8'h00);
    // R2 and R4: load pointer 3, one-shot view, then default again
    step(1'b1, 1'b1, A_ST, 8'h03, 1'b0, 8'h00, 1'b0);
    step(1'b1, 1'b0, A_ST, 8'h00, 1'b0, 8'h00, 1'b0);
    step(1'b1, 1'b0, A_ST, 8'h00, 1'b0, 8'h00, 1'b0);
    // R10: arrival with no enable sets the receive flag
    idle(1'b1, 8'hA5, 1'b0);
    #1 chk(irq, "R10", {7'd0, irq}, 8'h01);
    step(1'b1, 1'b0, A_ST, 8'h00, 1'b1, 8'hA5, 1'b0);
    step(1'b1, 1'b1, A_ST, 8'h03, 1'b1, 8'hA5, 1'b0);
    step(1'b1, 1'b0, A_ST, 8'h00, 1'b1, 8'hA5, 1'b0);
    // R6: transmit write, then R4 priority of transmit
    step(1'b1, 1'b1, A_DT, 8'h5A, 1'b1, 8'hA5, 1'b0);
    step(1'b1, 1'b1, A_ST, 8'h03, 1'b1, 8'hA5, 1'b0);
    step(1'b1, 1'b0, A_ST, 8'h00, 1'b1, 8'hA5, 1'b0);
    // R8: pop the byte
    step(1'b1, 1'b0, A_DT, 8'h00, 1'b1, 8'hA5, 1'b0);
    idle(1'b0, 8'h00, 1'b0);
    // R5 with R10 in the same cycle: ack while a new byte arrives
    step(1'b1, 1'b1, A_ST, 8'h28, 1'b1, 8'h3C, 1'b0);
    #1 chk(irq, "R5", {7'd0, irq}, 8'h01);
    step(1'b1, 1'b0, A_DT, 8'h00, 1'b1, 8'h3C, 1'b1);
    idle(1'b0, 8'h00, 1'b0);
    #1 chk(!irq, "R11", {7'd0, irq}, 8'h00);
    // R5: rejected ack leaves pointer 3 in place
    step(1'b1, 1'b1, A_ST, 8'h03, 1'b0, 8'h00, 1'b0);
    step(1'b1, 1'b1, A_ST, 8'h28, 1'b0, 8'h00, 1'b0);
    step(1'b1, 1'b0, A_ST, 8'h00, 1'b0, 8'h00, 1'b0);
    // R9: empty data read
    step(1'b1, 1'b0, A_DT, 8'h00, 1'b0, 8'h77, 1'b0);
    // R7: write while busy drops the byte
    step(1'b1, 1'b1, A_DT, 8'h11, 1'b0, 8'h00, 1'b0);
    step(1'b1, 1'b1, A_DT, 8'h22, 1'b0, 8'h00, 1'b0);
    idle(1'b0, 8'h00, 1'b1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ad, wd;
      int unsigned r;
      r  = $urandom_range(0, 9);
      ad = (r < 5) ? A_ST : ((r < 9) ? A_DT : 8'h40);
      r  = $urandom_range(0, 5);
      wd = (r == 0) ? 8'h28 : ((r == 1) ? 8'h03 : ((r == 2) ? 8'h00 : 8'($urandom)));
      step(1'($urandom_range(0, 3) != 0), 1'($urandom), ad, wd,
           1'($urandom), 8'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule